// File: doc/BRIEF.md
# Latching Interrupt Controller with Selectable Clear Policy

This block gathers a bank of interrupt lines (32 by default) into one interrupt request for a processor. Each line owns one bit in an enable word and one bit in a pending word. The processor reaches both words through a small register port: one select bit, a write strobe, a write word and a read word. The request output goes high one cycle after any line is both pending and enabled. Software reads the pending word and services the lowest-numbered set bit first, so line 0 has the highest service priority.

A build-time parameter selects how pending bits behave. In the edge policy, a rising edge on a line sets its bit, and software clears the bit by writing a one to it. In the follow policy, the pending word simply mirrors the synchronized line levels, and writes to it do nothing. In the legacy policy, a high level is latched and stays latched. Software clears it by writing a word that is ANDed into the pending word, so zeros clear bits and ones keep them.

All inputs pass through a synchronizer chain before they are used. A hardware set and a software clear that land on the same bit in the same cycle resolve in favour of the set, so no event is lost.

Top module: `line_intc`

## Requirements
- R1: While reset is held and right after it, the enable word and the pending word read as zero and `cpuIrq` is low.
- R2: A write with `regSel`=0 replaces the whole enable word with `regWdata`, and it reads back from the next cycle. Bit n enables line n. With no such write, the enable word does not change.
- R3: Edge policy: a rising edge on a line sets its pending bit. The bit stays set after the line falls.
- R4: Edge policy: a write with `regSel`=1 clears every pending bit written as 1 and leaves every bit written as 0 unchanged.
- R5: Legacy policy: a high line latches its pending bit. The bit stays set after the line falls.
- R6: Legacy policy: a write with `regSel`=1 ANDs `regWdata` into the pending word. Bits written 0 clear and bits written 1 are kept.
- R7: Follow policy: the pending word equals the synchronized line levels. Writes with `regSel`=1 have no effect on it.
- R8: `cpuIrq` equals the OR of (pending AND enable) as it stood one clock earlier.
- R9: When a set and a software clear hit the same pending bit in the same cycle, the bit ends set.
- R10: A line change set up before a clock edge shows in the pending word after the third edge, and not after the second.
- R11: With the enable word all zeros, `cpuIrq` stays low, and the pending bits are still reported.
- R12: Edge policy: a line held high after its bit was cleared does not set the bit again until a new rising edge arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irqLines | input | NUM_LINES | Interrupt lines, asynchronous to clk |
| regSel | input | 1 | Register select: 0 enable word, 1 pending word |
| regWe | input | 1 | Write strobe for the selected register |
| regWdata | input | NUM_LINES | Write word |
| regRdata | output | NUM_LINES | Selected register, read combinationally |
| cpuIrq | output | 1 | Registered interrupt request |

## Verification
The bench builds three copies side by side, one for each clear policy. All three use the default 32 lines and a two-stage synchronizer, and they share the same stimulus. Because of that, every policy's answer to the same input or write shows up at the same moment. The bench walks a single active line across all 32 positions, so every bit's latch, clear, enable and request path gets exercised. Targeted sequences then land a set and a clear on the same edge and hold a line high through a clear.

// File: rtl/intc_pkg.sv
package intc_pkg;

  typedef enum logic [1:0] {
    CLR_WRITE_ONE    = 2'd0,
    CLR_LEVEL_FOLLOW = 2'd1,
    CLR_WRITE_ZERO   = 2'd2
  } clrMode_e;

  typedef struct packed {
    logic maskLoad;
    logic statusWrite;
    logic readStatus;
  } ctrlStrobes_t;

endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= '0;
          else        chain[0] <= asyncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import intc_pkg::*;
#(
  parameter clrMode_e MODE = CLR_WRITE_ONE
) (
  input  logic         regSel,
  input  logic         regWe,
  output ctrlStrobes_t strobes
);
  localparam bit STATUS_WRITABLE = (MODE != CLR_LEVEL_FOLLOW);

  always_comb begin
    strobes.maskLoad    = regWe & ~regSel;
    strobes.statusWrite = regWe & regSel & STATUS_WRITABLE;
    strobes.readStatus  = regSel;
  end
endmodule

// File: rtl/intc_datapath.sv
module intc_datapath
  import intc_pkg::*;
#(
  parameter int       NUM_LINES = 32,
  parameter clrMode_e MODE      = CLR_WRITE_ONE
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  ctrlStrobes_t         strobes,
  input  logic [NUM_LINES-1:0] wdata,
  input  logic [NUM_LINES-1:0] syncLevel,
  output logic [NUM_LINES-1:0] statusQ,
  output logic [NUM_LINES-1:0] maskQ,
  output logic [NUM_LINES-1:0] rdData,
  output logic                 irqQ
);
  logic [NUM_LINES-1:0] statusNext;

  generate
    if (MODE == CLR_WRITE_ONE) begin : g_edge
      logic [NUM_LINES-1:0] prevLevel;
      logic [NUM_LINES-1:0] riseVec;
      logic [NUM_LINES-1:0] keepVec;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prevLevel <= '0;
        else        prevLevel <= syncLevel;
      end

      always_comb begin
        riseVec    = syncLevel & ~prevLevel;
        keepVec    = strobes.statusWrite ? ~wdata : '1;
        statusNext = (statusQ & keepVec) | riseVec;
      end
    end else if (MODE == CLR_WRITE_ZERO) begin : g_legacy
      logic [NUM_LINES-1:0] keepVec;

      always_comb begin
        keepVec    = strobes.statusWrite ? wdata : '1;
        statusNext = (statusQ & keepVec) | syncLevel;
      end
    end else begin : g_follow
      logic unusedStatusWrite;
      assign unusedStatusWrite = strobes.statusWrite;

      always_comb statusNext = syncLevel;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      statusQ <= '0;
      maskQ   <= '0;
      irqQ    <= 1'b0;
    end else begin
      statusQ <= statusNext;
      if (strobes.maskLoad) maskQ <= wdata;
      irqQ <= |(statusQ & maskQ);
    end
  end

  assign rdData = strobes.readStatus ? statusQ : maskQ;
endmodule

// File: rtl/line_intc.sv
module line_intc
  import intc_pkg::*;
#(
  parameter int       NUM_LINES   = 32,
  parameter int       SYNC_STAGES = 2,
  parameter clrMode_e MODE        = CLR_WRITE_ONE
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irqLines,
  input  logic                 regSel,
  input  logic                 regWe,
  input  logic [NUM_LINES-1:0] regWdata,
  output logic [NUM_LINES-1:0] regRdata,
  output logic                 cpuIrq
);
  ctrlStrobes_t         strobes;
  logic [NUM_LINES-1:0] syncLevel;
  logic [NUM_LINES-1:0] statusVec;
  logic [NUM_LINES-1:0] maskVec;

  intc_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .asyncIn (irqLines),
    .syncOut (syncLevel)
  );

  intc_ctrl #(.MODE(MODE)) u_ctrl (
    .regSel  (regSel),
    .regWe   (regWe),
    .strobes (strobes)
  );

  intc_datapath #(.NUM_LINES(NUM_LINES), .MODE(MODE)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobes   (strobes),
    .wdata     (regWdata),
    .syncLevel (syncLevel),
    .statusQ   (statusVec),
    .maskQ     (maskVec),
    .rdData    (regRdata),
    .irqQ      (cpuIrq)
  );
endmodule

// File: rtl/line_intc_checker.sv
module line_intc_checker
  import intc_pkg::*;
#(
  parameter int       NUM_LINES = 32,
  parameter clrMode_e MODE      = CLR_WRITE_ONE
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 regSel,
  input logic                 regWe,
  input logic [NUM_LINES-1:0] regWdata,
  input logic [NUM_LINES-1:0] statusVec,
  input logic [NUM_LINES-1:0] maskVec,
  input logic                 cpuIrq
);
  logic maskWr;
  logic statWr;
  assign maskWr = regWe && !regSel;
  assign statWr = regWe && regSel;

  p_mask_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    maskWr |=> (maskVec == $past(regWdata)));

  p_mask_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !maskWr |=> $stable(maskVec));

  p_irq_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(statusVec & maskVec)) |=> cpuIrq);

  p_irq_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(statusVec & maskVec)) |=> !cpuIrq);

  p_masked_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (maskVec == '0) |=> !cpuIrq);

  generate
    if (MODE == CLR_WRITE_ONE) begin : g_edge_chk
      p_zero_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        statWr |=> ((($past(statusVec) & ~$past(regWdata)) & ~statusVec) == '0));
      p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !statWr |=> (($past(statusVec) & ~statusVec) == '0));
    end else if (MODE == CLR_WRITE_ZERO) begin : g_legacy_chk
      p_one_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
        statWr |=> ((($past(statusVec) & $past(regWdata)) & ~statusVec) == '0));
      p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !statWr |=> (($past(statusVec) & ~statusVec) == '0));
    end
  endgenerate
endmodule

bind line_intc line_intc_checker #(.NUM_LINES(NUM_LINES), .MODE(MODE)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .regSel    (regSel),
  .regWe     (regWe),
  .regWdata  (regWdata),
  .statusVec (statusVec),
  .maskVec   (maskVec),
  .cpuIrq    (cpuIrq)
);

// File: tb/line_intc_test.sv
module line_intc_test;
  import intc_pkg::*;
  localparam int N = 32;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic         rst_n;
  logic [N-1:0] lines;
  logic         regSel;
  logic         regWe;
  logic [N-1:0] wdata;
  logic [N-1:0] rdE, rdL, rdG;
  logic         irqE, irqL, irqG;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  line_intc #(.NUM_LINES(N), .MODE(CLR_WRITE_ONE)) uut (
    .clk(clk), .rst_n(rst_n), .irqLines(lines), .regSel(regSel), .regWe(regWe),
    .regWdata(wdata), .regRdata(rdE), .cpuIrq(irqE));

  line_intc #(.NUM_LINES(N), .MODE(CLR_LEVEL_FOLLOW)) uutLevel (
    .clk(clk), .rst_n(rst_n), .irqLines(lines), .regSel(regSel), .regWe(regWe),
    .regWdata(wdata), .regRdata(rdL), .cpuIrq(irqL));

  line_intc #(.NUM_LINES(N), .MODE(CLR_WRITE_ZERO)) uutLegacy (
    .clk(clk), .rst_n(rst_n), .irqLines(lines), .regSel(regSel), .regWe(regWe),
    .regWdata(wdata), .regRdata(rdG), .cpuIrq(irqG));

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic sel, input logic [N-1:0] d);
    regSel = sel;
    wdata  = d;
    regWe  = 1'b1;
    @(negedge clk);
    regWe  = 1'b0;
    wdata  = '0;
  endtask

  task automatic pick(input logic sel);
    regSel = sel;
    #1;
  endtask

  function automatic logic [N-1:0] irqVec();
    return {{(N-3){1'b0}}, irqE, irqL, irqG};
  endfunction

  logic [N-1:0] pat;

  initial begin
    rst_n = 1'b0; lines = '0; regSel = 1'b0; regWe = 1'b0; wdata = '0;
    cyc(3);
    pick(1'b0);
    chk("R1 mask in reset", rdE | rdL | rdG, '0);
    pick(1'b1);
    chk("R1 status in reset", rdE | rdL | rdG, '0);
    chk("R1 irq in reset", irqVec(), '0);
    rst_n = 1'b1;
    cyc(2);
    pick(1'b1);
    chk("R1 status after reset", rdE | rdL | rdG, '0);
    chk("R1 irq after reset", irqVec(), '0);

    for (int i = 0; i < N; i++) begin
      logic [N-1:0] bitI;
      bitI  = N'(1) << i;
      lines = bitI;
      cyc(2); pick(1'b1);
      chk("R10 not yet after two edges", rdE | rdL | rdG, '0);
      cyc(1); pick(1'b1);
      chk("R3/R10 edge set", rdE, bitI);
      chk("R5/R10 legacy latch", rdG, bitI);
      chk("R7/R10 follow level", rdL, bitI);
      chk("R11 masked no irq", irqVec(), '0);
      lines = '0;
      cyc(3); pick(1'b1);
      chk("R3 edge sticky", rdE, bitI);
      chk("R5 legacy sticky", rdG, bitI);
      chk("R7 follow drops", rdL, '0);
      wr(1'b0, bitI); pick(1'b0);
      chk("R2 mask readback", rdE & rdL & rdG, bitI);
      chk("R8 irq lags one cycle", irqVec(), '0);
      cyc(1);
      chk("R8 irq asserted", irqVec(), N'(3'b101));
      wr(1'b1, ~bitI); pick(1'b1);
      chk("R4 zero keeps", rdE, bitI);
      chk("R6 zero clears", rdG, '0);
      cyc(1);
      chk("R8 legacy irq drops", irqVec(), N'(3'b100));
      wr(1'b1, bitI); pick(1'b1);
      chk("R4 one clears", rdE, '0);
      cyc(1);
      chk("R8 edge irq drops", irqVec(), '0);
      wr(1'b0, '0);
    end

    pat = 32'hA5C3_0F18;
    lines = pat;
    cyc(3); pick(1'b1);
    chk("R3 multi edge", rdE, pat);
    chk("R5 multi legacy", rdG, pat);
    chk("R7 multi follow", rdL, pat);
    lines = '0;
    cyc(3); pick(1'b1);
    chk("R7 multi follow drop", rdL, '0);
    wr(1'b1, '1); pick(1'b1);
    chk("R4 clear all", rdE, '0);
    chk("R6 ones keep", rdG, pat);
    wr(1'b1, 32'hFFFF_0000); pick(1'b1);
    chk("R6 partial and", rdG, pat & 32'hFFFF_0000);
    wr(1'b1, '0); pick(1'b1);
    chk("R6 clear all", rdG, '0);

    for (int k = 0; k < 4; k++) begin
      logic [N-1:0] m;
      m = (k == 0) ? 32'h5A5A_F00F : (k == 1) ? 32'hFFFF_FFFF : (k == 2) ? 32'h8000_0001 : 32'h0;
      wr(1'b0, m); pick(1'b0);
      chk("R2 mask pattern", rdE, m);
      wr(1'b1, 32'h1234_5678); pick(1'b0);
      chk("R2 status write leaves mask", rdG, m);
    end

    lines = N'(1) << 7;
    cyc(3);
    wr(1'b0, '1);
    cyc(1);
    chk("R11 enabled irq high", irqVec(), N'(3'b111));
    wr(1'b0, '0);
    cyc(1); pick(1'b1);
    chk("R11 disabled irq low", irqVec(), '0);
    chk("R11 pending still reported", rdE, N'(1) << 7);
    wr(1'b1, N'(1) << 7); pick(1'b1);
    chk("R12 held line cleared", rdE, '0);
    cyc(5); pick(1'b1);
    chk("R12 no re-set while held", rdE, '0);
    wr(1'b1, '0); pick(1'b1);
    chk("R9 legacy level beats clear", rdG, N'(1) << 7);
    chk("R7 follow ignores zero write", rdL, N'(1) << 7);
    wr(1'b1, '1); pick(1'b1);
    chk("R7 follow ignores ones write", rdL, N'(1) << 7);
    lines = '0;
    cyc(3);
    wr(1'b1, '0); pick(1'b1);
    chk("R6 legacy cleared after drop", rdG, '0);

    lines = N'(1) << 3;
    cyc(3);
    lines = '0;
    cyc(3);
    lines = N'(1) << 3;
    cyc(2);
    wr(1'b1, N'(1) << 3); pick(1'b1);
    chk("R9 edge set beats clear", rdE, N'(1) << 3);
    lines = '0;
    cyc(3);
    wr(1'b1, '1); pick(1'b1);
    chk("R4 final clear", rdE, '0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule